// File: doc/BRIEF.md
# Bit-Time Timestamp Counter with Network Synchronisation

This block keeps a free-running 16-bit time base for a CAN controller. The count goes up by one on each bit-time tick that the bit timing logic supplies. Whenever a message is received or transmitted successfully, the block takes a snapshot of the count. It hands that snapshot, with the index of the buffer involved, to the message buffer storage as a one-cycle write.

Nodes on a network can share a common time base. When synchronisation is enabled, a successful receive or transmit on buffer 0 takes the snapshot and also restarts the counter from zero. The snapshot holds the value the counter had before the restart.

A receive and a transmit success may arrive in the same cycle. In that case the receive snapshot is written first and the transmit snapshot on the following cycle, and both carry the same value. After such a pair, the next strobe must come no earlier than one idle cycle later. Any other strobes may come in consecutive cycles.

Top module: `ts_stamp_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `count` becomes 0 and `cap_we` becomes 0 after that edge.
- R2: Without a sync restart, a clock edge with `bit_tick` high adds exactly one to `count`, and an edge with `bit_tick` low leaves `count` unchanged.
- R3: `count` wraps from 0xFFFF to 0x0000 on a tick and never saturates.
- R4: A cycle with `rx_ok` high (and `tx_ok` low) gives, after the next edge, `cap_we`=1 for exactly one cycle, with `cap_is_tx`=0, `cap_idx`=`rx_idx`, and `cap_value` equal to `count` in the strobe cycle.
- R5: A cycle with `tx_ok` high (and `rx_ok` low) gives the same kind of capture, but with `cap_is_tx`=1 and `cap_idx`=`tx_idx`.
- R6: With `sync_en`=1, a strobe whose index is 0 sets `count` to 0 after the edge, whatever `bit_tick` is. The capture for that strobe still carries the value from before the restart.
- R7: With `sync_en`=0, or with a strobe whose index is not 0, the strobe does not disturb `count`.
- R8: When `rx_ok` and `tx_ok` are high in the same cycle, the receive capture (`cap_is_tx`=0, `rx_idx`) appears first. The transmit capture (`cap_is_tx`=1, `tx_idx`) appears on the following cycle with the same `cap_value`. After that, `cap_we` drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per elapsed bit time |
| sync_en | input | 1 | Enables the restart of the count by buffer 0 traffic |
| rx_ok | input | 1 | Successful-receive strobe |
| rx_idx | input | 4 | Buffer index of the received message |
| tx_ok | input | 1 | Successful-transmit strobe |
| tx_idx | input | 4 | Buffer index of the transmitted message |
| count | output | 16 | Current bit-time count |
| cap_we | output | 1 | One-cycle write strobe for the timestamp |
| cap_is_tx | output | 1 | 1 if the capture comes from a transmit, 0 if from a receive |
| cap_idx | output | 4 | Buffer index the timestamp belongs to |
| cap_value | output | 16 | Captured timestamp |

## Verification
A wrong count shows on `count` one edge after the tick or strobe that caused it. The same wrong count also shows in `cap_value` at the next capture, so a restart or increment fault cannot hide between events. A lost or misordered pending transmit capture shows within two cycles of a simultaneous pair: `cap_we` is missing, `cap_is_tx` is wrong, or the value differs from its partner. The 0xFFFF boundary is reached by ticking the counter through its whole range.

// File: rtl/ts_pkg.sv
package ts_pkg;

    localparam int unsigned TS_WIDTH    = 16;
    localparam int unsigned TS_BUFFERS  = 15;
    localparam int unsigned TS_SYNC_BUF = 0;

    // Number of bits needed to name one of n buffers.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // True when a strobe on the given buffer must restart the time base.
    function automatic logic restart_hit(
        input logic        enable,
        input logic        strobe,
        input int unsigned idx,
        input int unsigned sync_buf
    );
        return enable && strobe && (idx == sync_buf);
    endfunction

endpackage

// File: rtl/ts_counter.sv
module ts_counter #(
    parameter int unsigned WIDTH = ts_pkg::TS_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    output logic [WIDTH-1:0] value
);
    logic [WIDTH-1:0] value_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            value_q <= '0;
        end else if (tick) begin
            value_q <= value_q + 1'b1;
        end
    end

    assign value = value_q;

    // R2, R3: a tick without a restart moves the count by exactly one (mod 2^WIDTH)
    a_r2_tick_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !restart) |=> (value_q == WIDTH'($past(value_q) + 1'b1)));

    // R2: no tick and no restart keeps the count
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart) |=> $stable(value_q));

    // R6: a restart leaves zero behind
    a_r6_restart_zero: assert property (@(posedge clk) disable iff (rst)
        restart |=> (value_q == '0));

endmodule

// File: rtl/ts_capture_seq.sv
module ts_capture_seq #(
    parameter int unsigned WIDTH = ts_pkg::TS_WIDTH,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] now,
    input  logic             rx_ok,
    input  logic [IDX_W-1:0] rx_idx,
    input  logic             tx_ok,
    input  logic [IDX_W-1:0] tx_idx,
    output logic             we,
    output logic             is_tx,
    output logic [IDX_W-1:0] idx,
    output logic [WIDTH-1:0] stamp
);
    typedef struct packed {
        logic             is_tx;
        logic [IDX_W-1:0] idx;
        logic [WIDTH-1:0] stamp;
    } cap_rec_t;

    cap_rec_t out_q, pend_q, rx_rec, tx_rec;
    logic     we_q, pend_valid_q;

    always_comb begin
        rx_rec = '{is_tx: 1'b0, idx: rx_idx, stamp: now};
        tx_rec = '{is_tx: 1'b1, idx: tx_idx, stamp: now};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q         <= 1'b0;
            out_q        <= '0;
            pend_q       <= '0;
            pend_valid_q <= 1'b0;
        end else begin
            we_q <= rx_ok || tx_ok || pend_valid_q;
            if (pend_valid_q) begin
                out_q        <= pend_q;
                pend_valid_q <= 1'b0;
            end else if (rx_ok) begin
                out_q <= rx_rec;
                if (tx_ok) begin
                    pend_q       <= tx_rec;
                    pend_valid_q <= 1'b1;
                end
            end else if (tx_ok) begin
                out_q <= tx_rec;
            end
        end
    end

    assign we    = we_q;
    assign is_tx = out_q.is_tx;
    assign idx   = out_q.idx;
    assign stamp = out_q.stamp;

    // R4, R5: every strobe is followed by a write
    a_r4_strobe_writes: assert property (@(posedge clk) disable iff (rst)
        (rx_ok || tx_ok) |=> we);

    // R4: a lone receive produces a receive record tagged with its index
    a_r4_rx_record: assert property (@(posedge clk) disable iff (rst)
        (rx_ok && !pend_valid_q) |=> (!is_tx && idx == $past(rx_idx)));

    // R8: a simultaneous pair gives receive then transmit, same stamp
    a_r8_pair_order: assert property (@(posedge clk) disable iff (rst)
        (rx_ok && tx_ok && !pend_valid_q) |=> (we && !is_tx) ##1 (we && is_tx && $stable(stamp)));

    // R4: a write with nothing pending and no new strobe lasts one cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (we && !pend_valid_q && !rx_ok && !tx_ok) |=> !we);

endmodule

// File: rtl/ts_stamp_unit.sv
module ts_stamp_unit #(
    parameter int unsigned WIDTH    = ts_pkg::TS_WIDTH,
    parameter int unsigned BUFFERS  = ts_pkg::TS_BUFFERS,
    parameter int unsigned SYNC_BUF = ts_pkg::TS_SYNC_BUF,
    localparam int unsigned IDX_W   = ts_pkg::idx_bits(BUFFERS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             sync_en,
    input  logic             rx_ok,
    input  logic [IDX_W-1:0] rx_idx,
    input  logic             tx_ok,
    input  logic [IDX_W-1:0] tx_idx,
    output logic [WIDTH-1:0] count,
    output logic             cap_we,
    output logic             cap_is_tx,
    output logic [IDX_W-1:0] cap_idx,
    output logic [WIDTH-1:0] cap_value
);
    logic restart;

    assign restart = ts_pkg::restart_hit(sync_en, rx_ok, int'(rx_idx), SYNC_BUF)
                  || ts_pkg::restart_hit(sync_en, tx_ok, int'(tx_idx), SYNC_BUF);

    ts_counter #(.WIDTH(WIDTH)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .tick    (bit_tick),
        .restart (restart),
        .value   (count)
    );

    ts_capture_seq #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_capture (
        .clk    (clk),
        .rst    (rst),
        .now    (count),
        .rx_ok  (rx_ok),
        .rx_idx (rx_idx),
        .tx_ok  (tx_ok),
        .tx_idx (tx_idx),
        .we     (cap_we),
        .is_tx  (cap_is_tx),
        .idx    (cap_idx),
        .stamp  (cap_value)
    );

    // R6: the capture taken on a restarting strobe holds the pre-restart count
    a_r6_stamp_before_restart: assert property (@(posedge clk) disable iff (rst)
        (restart && (rx_ok || tx_ok)) |=> (cap_we && cap_value == $past(count)));

    // R7: with sync disabled the count never falls to zero except by wrapping
    a_r7_no_restart_when_off: assert property (@(posedge clk) disable iff (rst)
        (!sync_en && !bit_tick) |=> $stable(count));

    // R1: reset clears the outputs
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (count == '0 && !cap_we));

endmodule

// File: tb/tb_ts_stamp_unit.sv
module tb_ts_stamp_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_tick = 1'b0, sync_en = 1'b0, rx_ok = 1'b0, tx_ok = 1'b0;
    logic [3:0]  rx_idx = '0, tx_idx = '0;
    logic [15:0] count, cap_value;
    logic        cap_we, cap_is_tx;
    logic [3:0]  cap_idx;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ts_stamp_unit dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .sync_en(sync_en),
        .rx_ok(rx_ok), .rx_idx(rx_idx), .tx_ok(tx_ok), .tx_idx(tx_idx),
        .count(count), .cap_we(cap_we), .cap_is_tx(cap_is_tx),
        .cap_idx(cap_idx), .cap_value(cap_value)
    );

    // {tick, sync, rx, rx_idx, tx, tx_idx, exp_count, exp_we, exp_tx, exp_idx, exp_val}
    typedef struct packed {
        logic        tick;
        logic        sync;
        logic        rx;
        logic [3:0]  rxi;
        logic        tx;
        logic [3:0]  txi;
        logic [15:0] ecnt;
        logic        ewe;
        logic        etx;
        logic [3:0]  eidx;
        logic [15:0] eval;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, 16'd1, 1'b0, 1'b0, 4'd0, 16'd0}, // R2
        '{1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, 16'd2, 1'b0, 1'b0, 4'd0, 16'd0}, // R2
        '{1'b1, 1'b0, 1'b1, 4'd3, 1'b0, 4'd0, 16'd3, 1'b1, 1'b0, 4'd3, 16'd2}, // R4
        '{1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, 16'd3, 1'b0, 1'b0, 4'd0, 16'd0}, // R2 hold, R4 pulse
        '{1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 4'd5, 16'd4, 1'b1, 1'b1, 4'd5, 16'd3}, // R5
        '{1'b1, 1'b1, 1'b1, 4'd0, 1'b0, 4'd0, 16'd0, 1'b1, 1'b0, 4'd0, 16'd4}, // R6 rx
        '{1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, 16'd1, 1'b0, 1'b0, 4'd0, 16'd0}, // R2
        '{1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 4'd0, 16'd2, 1'b1, 1'b1, 4'd0, 16'd1}, // R7 sync off
        '{1'b1, 1'b1, 1'b1, 4'd7, 1'b0, 4'd0, 16'd3, 1'b1, 1'b0, 4'd7, 16'd2}, // R7 other buf
        '{1'b0, 1'b1, 1'b0, 4'd0, 1'b1, 4'd0, 16'd0, 1'b1, 1'b1, 4'd0, 16'd3}, // R6 tx
        '{1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, 16'd0, 1'b0, 1'b0, 4'd0, 16'd0}  // R6 stays 0
    };

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic t, input logic s, input logic r, input logic [3:0] ri,
                         input logic x, input logic [3:0] xi);
        bit_tick = t; sync_en = s; rx_ok = r; rx_idx = ri; tx_ok = x; tx_idx = xi;
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_cap(input string req, input logic [3:0] ei, input logic etx,
                           input logic [15:0] ev);
        chk(cap_we == 1'b1, req, "cap_we", int'(cap_we), 1);
        chk(cap_is_tx == etx, req, "cap_is_tx", int'(cap_is_tx), int'(etx));
        chk(cap_idx == ei, req, "cap_idx", int'(cap_idx), int'(ei));
        chk(cap_value == ev, req, "cap_value", int'(cap_value), int'(ev));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        step;
        chk(count == 16'd0, "R1", "count after reset", int'(count), 0);
        chk(cap_we == 1'b0, "R1", "cap_we after reset", int'(cap_we), 0);
        rst = 1'b0;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].tick, VECS[i].sync, VECS[i].rx, VECS[i].rxi, VECS[i].tx, VECS[i].txi);
            step;
            chk(count == VECS[i].ecnt, "R2/R6/R7", $sformatf("vec%0d count", i),
                int'(count), int'(VECS[i].ecnt));
            chk(cap_we == VECS[i].ewe, "R4/R5", $sformatf("vec%0d cap_we", i),
                int'(cap_we), int'(VECS[i].ewe));
            if (VECS[i].ewe)
                chk_cap("R4/R5/R6", VECS[i].eidx, VECS[i].etx, VECS[i].eval);
        end

        // R8: simultaneous receive and transmit, no sync
        drive(1'b1, 1'b0, 1'b1, 4'd2, 1'b1, 4'd4);
        step;
        chk(count == 16'd1, "R8", "count", int'(count), 1);
        chk_cap("R8", 4'd2, 1'b0, 16'd0);
        drive(1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0);
        step;
        chk_cap("R8", 4'd4, 1'b1, 16'd0);
        step;
        chk(cap_we == 1'b0, "R8", "cap_we after pair", int'(cap_we), 0);

        // R8 with R6: pair where transmit hits buffer 0 under sync
        drive(1'b1, 1'b1, 1'b1, 4'd6, 1'b1, 4'd0);
        step;
        chk(count == 16'd0, "R6", "count after pair restart", int'(count), 0);
        chk_cap("R8", 4'd6, 1'b0, 16'd1);
        drive(1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0);
        step;
        chk_cap("R8", 4'd0, 1'b1, 16'd1);

        // R1: reset mid-run with a nonzero count
        drive(1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0);
        step; step; step;
        drive(1'b0, 1'b0, 1'b1, 4'd9, 1'b0, 4'd0);
        rst = 1'b1;
        step;
        chk(count == 16'd0, "R1", "count after mid reset", int'(count), 0);
        chk(cap_we == 1'b0, "R1", "cap_we after mid reset", int'(cap_we), 0);
        rst = 1'b0;

        // R3: tick through the full range
        drive(1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0);
        for (int k = 0; k < 65535; k++) @(posedge clk);
        @(negedge clk);
        chk(count == 16'hFFFF, "R3", "count at top", int'(count), 65535);
        drive(1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 4'd1);
        step;
        chk(count == 16'h0000, "R3", "count after wrap", int'(count), 0);
        chk_cap("R3", 4'd1, 1'b1, 16'hFFFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule